// File: doc/BRIEF.md
# Multi-Sensor Thermal Monitor Controller

This block polls up to three on-chip temperature converters and presents their readings to software through a 32-bit register bus. A single sequencer visits the enabled sensors in ascending round-robin order. It spaces the conversions by a programmable count N, so that one conversion starts every N+1 clock cycles. Each converter is a digital port. It returns a 12-bit raw code in the cycle when its request line is high, and the block captures the code at the end of that cycle.

Each sensor's captured code can pass straight to its data register, or it can first be averaged over a group of 2, 4, 8 or 16 conversions. Every update of a data register sets a data-ready flag. The same update is compared against two per-sensor thresholds, alarm and shutdown. A smaller code means a hotter die, so a flag is raised when the code is less than or equal to the threshold. The status flags are write-one-to-clear. One interrupt line combines every flag that is set and enabled.

The sequencer has three states. SQ_IDLE is the state with no sensor enabled. SQ_WAIT counts out the spacing. SQ_SAMPLE drives one request line. Its transitions are:
- IDLE to WAIT when any sensor is enabled.
- WAIT to SAMPLE when the count reaches N.
- SAMPLE to WAIT when N is nonzero.
- SAMPLE to SAMPLE when N is zero.
- WAIT or SAMPLE to IDLE when every enable is clear.

Top module: `thm_mon`

## Requirements
- R1: After reset every register reads 0, `irq` is low and no `conv_req` line is high.
- R2: Control2 (0x40) bits 2:0 enable sensors 0 to 2. A request goes only to an enabled sensor, and at most one line is high at a time. The enabled sensors are visited in ascending order, wrapping around. A disabled sensor is never requested.
- R3: With N in control0 (0x00) bits 15:0, successive conversion requests are exactly N+1 cycles apart. N=0 gives one request every cycle.
- R4: With averaging off, the data register of sensor i (0x80 + 4*i) holds the code captured in the last request cycle of that sensor, in bits 11:0. Bits 31:12 read 0. The new value is readable in the cycle after the request.
- R5: Filter register 0x70: bit 2 enables averaging, and bits 1:0 = k select groups of 2^(k+1) conversions. The data register takes the truncated mean of the group only when the group's last conversion is captured, and it holds its value in between. Any write to 0x70 restarts every group.
- R6: Each update of sensor i's data register sets data-ready status bit 8+i.
- R7: Threshold register 0x50 + 4*i holds the alarm level of sensor i in bits 11:0 and its shutdown level in bits 27:16. An update whose value is at or below the alarm level sets status bit i. An update at or below the shutdown level sets status bit 4+i.
- R8: Status (0x48, bits 10:0) clears each bit written with 1 and ignores bits written with 0. A flag raised in the same cycle as its clear stays set.
- R9: Interrupt control (0x44) enables status bits at the same positions (2:0, 6:4, 10:8). `irq` is high exactly while some status bit and its enable bit are both 1. Bits 31:12 of 0x44 are plain read/write storage.
- R10: The following are plain storage that reads back what was written: control1 bit 17, both calibration words (0x74, 0x78), and control2 bits 31:16. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| conv_req | output | NSENS | Per-sensor conversion request |
| conv_code | input | NSENS*12 | Raw codes, sensor i in bits 12*i+11:12*i |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle:
- The request vector is one-hot or zero, and it is never addressed to a disabled sensor.
- The request vector stays quiet when every enable is clear.
- A data register holds its value between updates, and an unfiltered update copies the captured code.
- Every update raises its data-ready flag.
- A write-one clear takes effect unless a new update arrives in the same cycle.

Only the bench scenarios can show the following:
- The exact N+1 spacing and the alternation between sensors.
- The averaged value appearing only on the last conversion of a group.
- The threshold comparisons in each direction.
- The enable masking of `irq`, and the storage registers reading back.

// File: rtl/thm_pkg.sv
package thm_pkg;
    localparam int ADDR_W = 8;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CTRL1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL2 = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_INTEN = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_FILT  = 8'h70;
    localparam logic [ADDR_W-1:0] OFF_CAL0  = 8'h74;
    localparam logic [ADDR_W-1:0] OFF_CAL1  = 8'h78;
    localparam int THR_BASE  = 'h50;
    localparam int DATA_BASE = 'h80;

    localparam int STAT_W = 11;
    localparam logic [STAT_W-1:0] STAT_MASK = 11'h777;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_SAMPLE
    } seq_state_e;
endpackage

// File: rtl/thm_seq.sv
module thm_seq
    import thm_pkg::*;
#(
    parameter int NSENS = 3,
    parameter int ACQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSENS-1:0] en,
    input  logic [ACQ_W-1:0] acq,
    output logic [NSENS-1:0] req
);
    localparam int IDX_W = (NSENS > 1) ? $clog2(NSENS) : 1;

    seq_state_e       state, nxt;
    logic [ACQ_W-1:0] cnt;
    logic [IDX_W-1:0] last, pick;
    logic             pick_ok;

    // next enabled sensor after the last one served, wrapping
    always_comb begin
        int cand;
        pick_ok = 1'b0;
        pick    = '0;
        for (int j = 1; j <= NSENS; j++) begin
            cand = int'(last) + j;
            if (cand >= NSENS) cand = cand - NSENS;
            if (!pick_ok && en[cand]) begin
                pick_ok = 1'b1;
                pick    = IDX_W'(cand);
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:   if (|en) nxt = SQ_WAIT;
            SQ_WAIT:   if (!(|en)) nxt = SQ_IDLE;
                       else if (cnt >= acq) nxt = SQ_SAMPLE;
            SQ_SAMPLE: if (!(|en)) nxt = SQ_IDLE;
                       else if (acq == '0) nxt = SQ_SAMPLE;
                       else nxt = SQ_WAIT;
            default:   nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            last <= IDX_W'(NSENS - 1);
        end else begin
            if (nxt == SQ_WAIT && state != SQ_WAIT) cnt <= ACQ_W'(1);
            else if (state == SQ_WAIT)              cnt <= cnt + 1'b1;
            if (state == SQ_SAMPLE && pick_ok)      last <= pick;
        end
    end

    always_comb begin
        req = '0;
        if (state == SQ_SAMPLE && pick_ok) req[pick] = 1'b1;
    end

    p_req_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));
    p_req_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req & ~en) == '0);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> (req == '0));
endmodule

// File: rtl/thm_avg.sv
module thm_avg #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [CODE_W-1:0] code,
    input  logic              fen,
    input  logic [1:0]        fsel,
    input  logic              restart,
    output logic              pub,
    output logic [CODE_W-1:0] pub_val,
    output logic [CODE_W-1:0] value
);
    localparam int ACC_W = CODE_W + 4;

    logic [ACC_W-1:0] acc, sum;
    logic [3:0]       num, last_num;
    logic [2:0]       shamt;

    assign last_num = 4'((5'd2 << fsel) - 5'd1);
    assign shamt    = {1'b0, fsel} + 3'd1;
    assign sum      = acc + ACC_W'(code);
    assign pub      = take && (!fen || (num == last_num && !restart));
    assign pub_val  = fen ? CODE_W'(sum >> shamt) : code;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc <= '0;
            num <= '0;
        end else if (take && fen) begin
            if (num == last_num) begin
                acc <= '0;
                num <= '0;
            end else begin
                acc <= sum;
                num <= num + 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (pub) value <= pub_val;
    end

    p_unfiltered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fen) |=> (value == $past(code)));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pub |=> $stable(value));
endmodule

// File: rtl/thm_mon.sv
module thm_mon
    import thm_pkg::*;
#(
    parameter int NSENS  = 3,
    parameter int CODE_W = 12,
    parameter int ACQ_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NSENS-1:0]        conv_req,
    input  logic [NSENS*CODE_W-1:0] conv_code,
    output logic                    irq
);
    logic             wr;
    logic [ACQ_W-1:0] acq_q;
    logic             cal_en_q;
    logic [15:0]      ctrl2_hi_q;
    logic [NSENS-1:0] sens_en_q;
    logic [STAT_W-1:0] inten_q, status_q, stat_set, stat_clr;
    logic [19:0]      intc_hi_q;
    logic [2:0]       filt_q;
    logic [31:0]      cal0_q, cal1_q;
    logic [CODE_W-1:0] thr_al_q [NSENS];
    logic [CODE_W-1:0] thr_sd_q [NSENS];
    logic [CODE_W-1:0] data_v [NSENS];
    logic [CODE_W-1:0] pub_v [NSENS];
    logic [NSENS-1:0] pub;
    logic             filt_wr;

    assign wr      = bus_sel && bus_wr;
    assign filt_wr = wr && bus_addr == OFF_FILT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_q <= '0; cal_en_q <= 1'b0; ctrl2_hi_q <= '0; sens_en_q <= '0;
            inten_q <= '0; intc_hi_q <= '0; filt_q <= '0;
            cal0_q <= '0; cal1_q <= '0;
            for (int i = 0; i < NSENS; i++) begin
                thr_al_q[i] <= '0;
                thr_sd_q[i] <= '0;
            end
        end else if (wr) begin
            case (bus_addr)
                OFF_CTRL0: acq_q <= bus_wdata[ACQ_W-1:0];
                OFF_CTRL1: cal_en_q <= bus_wdata[17];
                OFF_CTRL2: begin
                    ctrl2_hi_q <= bus_wdata[31:16];
                    sens_en_q  <= bus_wdata[NSENS-1:0];
                end
                OFF_INTEN: begin
                    inten_q   <= bus_wdata[STAT_W-1:0] & STAT_MASK;
                    intc_hi_q <= bus_wdata[31:12];
                end
                OFF_FILT:  filt_q <= bus_wdata[2:0];
                OFF_CAL0:  cal0_q <= bus_wdata;
                OFF_CAL1:  cal1_q <= bus_wdata;
                default: ;
            endcase
            for (int i = 0; i < NSENS; i++) begin
                if (bus_addr == ADDR_W'(THR_BASE + 4*i)) begin
                    thr_al_q[i] <= bus_wdata[CODE_W-1:0];
                    thr_sd_q[i] <= bus_wdata[16 +: CODE_W];
                end
            end
        end
    end

    thm_seq #(.NSENS(NSENS), .ACQ_W(ACQ_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(sens_en_q), .acq(acq_q), .req(conv_req)
    );

    for (genvar g = 0; g < NSENS; g++) begin : g_sens
        thm_avg #(.CODE_W(CODE_W)) u_avg (
            .clk(clk), .rst_n(rst_n), .take(conv_req[g]),
            .code(conv_code[g*CODE_W +: CODE_W]),
            .fen(filt_q[2]), .fsel(filt_q[1:0]), .restart(filt_wr),
            .pub(pub[g]), .pub_val(pub_v[g]), .value(data_v[g])
        );

        p_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pub[g] |=> status_q[8+g]);
        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && bus_addr == OFF_STAT && bus_wdata[8+g] && !pub[g])
            |=> !status_q[8+g]);
        p_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pub[g] && pub_v[g] <= thr_al_q[g]) |=> status_q[g]);
    end

    always_comb begin
        stat_set = '0;
        for (int i = 0; i < NSENS; i++) begin
            stat_set[8+i] = pub[i];
            stat_set[i]   = pub[i] && (pub_v[i] <= thr_al_q[i]);
            stat_set[4+i] = pub[i] && (pub_v[i] <= thr_sd_q[i]);
        end
        stat_clr = (wr && bus_addr == OFF_STAT) ? bus_wdata[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (stat_set | (status_q & ~stat_clr)) & STAT_MASK;
    end

    assign irq = |(status_q & inten_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFF_CTRL0: bus_rdata = 32'(acq_q);
                OFF_CTRL1: bus_rdata = 32'(cal_en_q) << 17;
                OFF_CTRL2: bus_rdata = {ctrl2_hi_q, 16'(sens_en_q)};
                OFF_INTEN: bus_rdata = {intc_hi_q, 1'b0, inten_q};
                OFF_STAT:  bus_rdata = 32'(status_q);
                OFF_FILT:  bus_rdata = 32'(filt_q);
                OFF_CAL0:  bus_rdata = cal0_q;
                OFF_CAL1:  bus_rdata = cal1_q;
                default:   bus_rdata = '0;
            endcase
            for (int i = 0; i < NSENS; i++) begin
                if (bus_addr == ADDR_W'(DATA_BASE + 4*i)) bus_rdata = 32'(data_v[i]);
                if (bus_addr == ADDR_W'(THR_BASE + 4*i))
                    bus_rdata = 32'(thr_al_q[i]) | (32'(thr_sd_q[i]) << 16);
            end
        end
    end
endmodule

// File: tb/thm_mon_bench.sv
module thm_mon_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [2:0]  conv_req;
    logic [35:0] conv_code;
    logic        irq;

    logic [11:0] base [3];
    logic [11:0] step [3];
    int rq [3];
    int cyc = 0, nlog = 0;
    int log_idx [32];
    int log_cyc [32];
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    thm_mon u_thm_mon (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_req(conv_req), .conv_code(conv_code), .irq(irq)
    );

    // converter model: code of the k-th request (k from 0) is base + k*step
    always_comb begin
        for (int s = 0; s < 3; s++)
            conv_code[s*12 +: 12] = base[s] +
                12'(int'(step[s]) * (rq[s] - int'(conv_req[s])));
    end

    initial begin
        for (int s = 0; s < 3; s++) begin
            rq[s] = 0; base[s] = 12'h001; step[s] = '0;
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (conv_req != '0) begin
            for (int s = 0; s < 3; s++) begin
                if (conv_req[s]) begin
                    rq[s] = rq[s] + 1;
                    if (nlog < 32) begin
                        log_idx[nlog] = s;
                        log_cyc[nlog] = cyc;
                    end
                end
            end
            nlog = nlog + 1;
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwr(logic [7:0] a, logic [31:0] d);
        tick();
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_req(int s, int target);
        while (rq[s] < target) tick();
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic [7:0] offs [11] = '{8'h00, 8'h04, 8'h40, 8'h44, 8'h48, 8'h70,
                                  8'h74, 8'h78, 8'h80, 8'h84, 8'h88};
        foreach (offs[k]) begin
            brd(offs[k], v);
            chk($sformatf("R1 reset reg %h", offs[k]), v, 32'h0);
        end
        chk("R1 reset irq", 32'(irq), 32'h0);
        chk("R1 reset conv_req", 32'(conv_req), 32'h0);
    endtask

    task automatic t_storage();
        logic [31:0] v;
        bwr(8'h74, 32'hdeadbeef); brd(8'h74, v); chk("R10 cal0", v, 32'hdeadbeef);
        bwr(8'h78, 32'h12345678); brd(8'h78, v); chk("R10 cal1", v, 32'h12345678);
        bwr(8'h04, 32'hffffffff); brd(8'h04, v); chk("R10 ctrl1", v, 32'h00020000);
        bwr(8'h40, 32'h5a5a0000); brd(8'h40, v); chk("R10 ctrl2 hi", v, 32'h5a5a0000);
        bwr(8'h10, 32'hffffffff); brd(8'h10, v); chk("R10 unmapped", v, 32'h0);
        bwr(8'h04, 32'h0);
    endtask

    task automatic t_interval();
        logic [31:0] v;
        int r1 = rq[1];
        base[0] = 12'h111; base[2] = 12'h333;
        bwr(8'h00, 32'd5);
        nlog = 0;
        bwr(8'h40, 32'h5);
        while (nlog < 5) tick();
        bwr(8'h40, 32'h0);
        for (int k = 0; k < 4; k++) begin
            chk("R3 gap N=5", 32'(log_cyc[k+1] - log_cyc[k]), 32'd6);
            chk("R2 alternation", 32'(log_idx[k+1] != log_idx[k]), 32'd1);
            chk("R2 enabled only", 32'(log_idx[k] == 0 || log_idx[k] == 2), 32'd1);
        end
        chk("R2 disabled sensor never requested", 32'(rq[1] - r1), 32'd0);
        brd(8'h84, v); chk("R2 disabled sensor data", v, 32'h0);
        bwr(8'h00, 32'd0);
        nlog = 0;
        bwr(8'h40, 32'h2);
        while (nlog < 5) tick();
        bwr(8'h40, 32'h0);
        for (int k = 0; k < 4; k++) begin
            chk("R3 gap N=0", 32'(log_cyc[k+1] - log_cyc[k]), 32'd1);
            chk("R2 single sensor", 32'(log_idx[k]), 32'd1);
        end
    endtask

    task automatic t_data();
        logic [31:0] v;
        base[1] = 12'habc; step[1] = '0;
        bwr(8'h48, 32'h777);
        bwr(8'h00, 32'd1);
        bwr(8'h40, 32'h2);
        wait_req(1, rq[1] + 1);
        bwr(8'h40, 32'h0);
        brd(8'h84, v); chk("R4 data1 value", v, 32'h00000abc);
        brd(8'h48, v); chk("R6 ready bit9", v & 32'h200, 32'h200);
    endtask

    task automatic t_filter();
        logic [31:0] v, old;
        int r0;
        bwr(8'h48, 32'h777);
        bwr(8'h70, 32'h5);
        base[0] = 12'd100; step[0] = 12'd8;
        r0 = rq[0];
        base[0] = 12'(100 - 8 * r0);
        brd(8'h80, old);
        bwr(8'h00, 32'd3);
        bwr(8'h40, 32'h1);
        wait_req(0, r0 + 3);
        brd(8'h80, v); chk("R5 no update mid-group", v, old);
        brd(8'h48, v); chk("R5 no ready mid-group", v & 32'h100, 32'h0);
        wait_req(0, r0 + 4);
        bwr(8'h40, 32'h0);
        brd(8'h80, v); chk("R5 mean of four", v, 32'd112);
        brd(8'h48, v); chk("R6 ready after group", v & 32'h100, 32'h100);
        bwr(8'h70, 32'h0);
        step[0] = '0;
    endtask

    task automatic t_thresh();
        logic [31:0] v;
        bwr(8'h48, 32'h777);
        bwr(8'h58, 32'h01000300);
        brd(8'h58, v); chk("R7 threshold readback", v, 32'h01000300);
        bwr(8'h44, 32'h70);
        base[2] = 12'h200; step[2] = '0;
        bwr(8'h00, 32'd2);
        bwr(8'h40, 32'h4);
        wait_req(2, rq[2] + 1);
        bwr(8'h40, 32'h0);
        brd(8'h48, v); chk("R7 alarm only", v, 32'h404);
        chk("R9 irq masked", 32'(irq), 32'h0);
        bwr(8'h44, 32'h1074);
        brd(8'h44, v); chk("R9 intc readback", v, 32'h1074);
        chk("R9 irq on alarm", 32'(irq), 32'h1);
        bwr(8'h48, 32'h004);
        brd(8'h48, v); chk("R8 w1c single bit", v, 32'h400);
        chk("R9 irq drops", 32'(irq), 32'h0);
        base[2] = 12'h080;
        bwr(8'h40, 32'h4);
        wait_req(2, rq[2] + 1);
        bwr(8'h40, 32'h0);
        brd(8'h48, v); chk("R7 shutdown and alarm", v, 32'h444);
        chk("R9 irq on shutdown", 32'(irq), 32'h1);
        bwr(8'h48, 32'h777);
        brd(8'h48, v); chk("R8 clear all", v, 32'h0);
        chk("R9 irq low", 32'(irq), 32'h0);
        bwr(8'h44, 32'h0);
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        base[0] = 12'h7ff;
        bwr(8'h00, 32'd0);
        bwr(8'h40, 32'h1);
        wait_req(0, rq[0] + 3);
        bwr(8'h48, 32'h100);
        brd(8'h48, v); chk("R8 set wins over clear", v & 32'h100, 32'h100);
        bwr(8'h40, 32'h0);
        tick(); tick();
        bwr(8'h48, 32'h100);
        brd(8'h48, v); chk("R8 clear when idle", v, 32'h0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_storage();
        t_interval();
        t_data();
        t_filter();
        t_thresh();
        t_setwins();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule